// File: doc/BRIEF.md
# Signed Decade Results Counter with Range Flags

This block accumulates the result of an integrating converter in a sign-and-magnitude BCD counter. The sequencer steps the counter up or down by a power of ten chosen per cycle: coarse steps for the first ramp and finer ones for each later correction. The counter passes through zero cleanly: a step that would take the magnitude below zero flips the sign and keeps counting in magnitude. It never wraps.

A conversion-end strobe closes a conversion. It captures the reading for the display, updates the over-range and under-range flags and clears the counter for the next conversion. It also starts an active-low latch strobe of fixed length. The reading is the counter with its lowest decade dropped. A two-bit mode input selects how the display follows the counter. In free-run mode it loads at every conversion end. In hold mode it keeps the old reading and the old flags. In transparent mode it shows the live counter.

Top module: `decade_result_counter`

## Requirements
- R1: After reset the counter is +0, the displayed reading is +0, both range flags are low and the latch strobe `latch_n` is high.
- R2: With `cnt_en` high, the signed value changes by 10^`wsel`, with decimal carry and borrow across all decades. `cnt_down`=0 adds and `cnt_down`=1 subtracts. A `wsel` of DECADES or more, or `cnt_en` low, leaves the counter unchanged.
- R3: A step that would take the magnitude below zero flips the sign, and the new magnitude is the weight minus the old magnitude. A zero magnitude always carries a positive sign (`rd_neg`=0).
- R4: A step that would push the magnitude past all nines leaves it at all nines. The magnitude never wraps.
- R5: The reading `rd_mag` is the counter magnitude with its lowest decade dropped. It is packed BCD, with the most significant decade in the top nibble.
- R6: In the cycle after `conv_end`, the counter is +0. Any step requested in the `conv_end` cycle is ignored.
- R7: `latch_n` goes low in the cycle after `conv_end` and stays low for LATCH_CYCLES cycles. A new `conv_end` while it is low restarts the count.
- R8: Modes 2'b00 and 2'b11 are free-run. In free-run, the reading and sign load from the counter at `conv_end` and are otherwise steady.
- R9: At `conv_end` in any mode other than hold, `over_rng` is set if the reading magnitude exceeds 19999 and `under_rng` is set if it is below 1000, regardless of sign. Otherwise both flags are low.
- R10: Mode 2'b01 is hold. In hold, `conv_end` leaves the reading, the sign and both flags unchanged, but `latch_n` still pulses and the counter is still cleared.
- R11: Mode 2'b10 is transparent. In transparent mode, `rd_mag` and `rd_neg` follow the live counter, and the flags still update at `conv_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Perform one counting step this cycle |
| cnt_down | input | 1 | 1 subtracts the weight, 0 adds it |
| wsel | input | 3 | Decade index of the step weight (10^wsel) |
| conv_end | input | 1 | Conversion-end strobe: capture, flag update, clear |
| lh_mode | input | 2 | 00/11 free-run, 01 hold, 10 transparent |
| rd_mag | output | 20 | Displayed reading magnitude, packed BCD |
| rd_neg | output | 1 | Displayed reading sign, 1 = negative |
| over_rng | output | 1 | Reading magnitude above 19999 |
| under_rng | output | 1 | Reading magnitude below 1000 |
| latch_n | output | 1 | Active-low display latch strobe |

## Verification
A table of single steps drives the counter in transparent mode. The steps mix every weight with both directions and both signs. This separates carry from borrow ripple, a sign flip from a plain decrement, and a result that lands on exactly zero from one that passes through it. Directed sequences then load magnitudes at the flag boundaries: 19999 against 20000, 1000 against 999, and a negative 20000. These show whether the thresholds act on the reading or on the raw count, and whether they ignore the sign. A run to all nines checks the saturation. Capturing the same stimulus in free-run, hold and transparent mode separates the three display behaviours and checks whether the flags follow the mode.

// File: rtl/decade_result_counter.sv
module decade_result_counter #(
  parameter int DECADES      = 6,
  parameter int LATCH_CYCLES = 100,
  localparam int W  = 4 * DECADES,
  localparam int SW = W - 4,
  localparam int WS = (DECADES > 1) ? $clog2(DECADES) : 1,
  localparam int LW = $clog2(LATCH_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_down,
  input  logic [WS-1:0] wsel,
  input  logic          conv_end,
  input  logic [1:0]    lh_mode,
  output logic [SW-1:0] rd_mag,
  output logic          rd_neg,
  output logic          over_rng,
  output logic          under_rng,
  output logic          latch_n
);

  localparam logic [W-1:0] NINES = {DECADES{4'h9}};

  function automatic logic [W:0] bcd_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic c;
    logic [4:0] s;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < DECADES; i++) begin
      s = {1'b0, a[4*i+:4]} + {1'b0, b[4*i+:4]} + {4'd0, c};
      c = (s >= 5'd10);
      r[4*i+:4] = c ? 4'(s - 5'd10) : s[3:0];
    end
    return {c, r};
  endfunction

  function automatic logic [W:0] bcd_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic c;
    logic [4:0] s;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < DECADES; i++) begin
      s = {1'b0, a[4*i+:4]} - {1'b0, b[4*i+:4]} - {4'd0, c};
      c = s[4];
      r[4*i+:4] = c ? 4'(s + 5'd10) : s[3:0];
    end
    return {c, r};
  endfunction

  logic [W-1:0]  cnt_q, wvec, nxt_mag;
  logic          neg_q, nxt_neg;
  logic [W:0]    sum_w, dif_w, rev_w;
  logic [SW-1:0] disp_q;
  logic          dneg_q, or_q, ur_q;
  logic [LW-1:0] lcnt_q;

  always_comb begin
    wvec = '0;
    for (int i = 0; i < DECADES; i++)
      if (wsel == WS'(i)) wvec[4*i+:4] = 4'd1;
  end

  assign sum_w = bcd_add(cnt_q, wvec);
  assign dif_w = bcd_sub(cnt_q, wvec);
  assign rev_w = bcd_sub(wvec, cnt_q);

  always_comb begin
    if (cnt_down == neg_q) begin
      nxt_mag = sum_w[W] ? NINES : sum_w[W-1:0];
      nxt_neg = neg_q;
    end else if (dif_w[W] && !rev_w[W]) begin
      nxt_mag = rev_w[W-1:0];
      nxt_neg = !neg_q;
    end else begin
      nxt_mag = dif_w[W-1:0];
      nxt_neg = neg_q;
    end
    if (nxt_mag == '0) nxt_neg = 1'b0;
  end

  wire hold_m   = (lh_mode == 2'b01);
  wire transp_m = (lh_mode == 2'b10);
  wire over_c   = (cnt_q[W-1 -: 4] >= 4'd2);
  wire under_c  = (cnt_q[W-1 -: 8] == 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      neg_q <= 1'b0;
    end else if (conv_end) begin
      cnt_q <= '0;
      neg_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= nxt_mag;
      neg_q <= nxt_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_q <= '0;
      dneg_q <= 1'b0;
      or_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else if (conv_end && !hold_m) begin
      disp_q <= cnt_q[W-1:4];
      dneg_q <= neg_q;
      or_q   <= over_c;
      ur_q   <= under_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             lcnt_q <= '0;
    else if (conv_end)      lcnt_q <= LW'(LATCH_CYCLES);
    else if (lcnt_q != '0)  lcnt_q <= lcnt_q - 1'b1;
  end

  assign latch_n   = (lcnt_q == '0);
  assign rd_mag    = transp_m ? cnt_q[W-1:4] : disp_q;
  assign rd_neg    = transp_m ? neg_q : dneg_q;
  assign over_rng  = or_q;
  assign under_rng = ur_q;

endmodule

// File: rtl/decade_result_counter_chk.sv
module decade_result_counter_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         cnt_down,
  input logic         conv_end,
  input logic [1:0]   lh_mode,
  input logic         latch_n,
  input logic         over_rng,
  input logic         under_rng,
  input logic [W-1:0] cnt_q,
  input logic         neg_q
);
  localparam logic [W-1:0] NINES = {(W/4){4'h9}};

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !conv_end) |=> ($stable(cnt_q) && $stable(neg_q)));

  p_zero_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !neg_q);

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !conv_end && !cnt_down && !neg_q && cnt_q == NINES) |=> (cnt_q == NINES));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> (cnt_q == '0 && !neg_q));

  p_strobe_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !latch_n);

  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_n) |-> $past(conv_end));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    over_rng |-> !under_rng);

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && lh_mode == 2'b01) |=> ($stable(over_rng) && $stable(under_rng)));
endmodule

bind decade_result_counter decade_result_counter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_down(cnt_down),
  .conv_end(conv_end), .lh_mode(lh_mode), .latch_n(latch_n),
  .over_rng(over_rng), .under_rng(under_rng), .cnt_q(cnt_q), .neg_q(neg_q)
);

// File: tb/decade_result_counter_tb.sv
`timescale 1ns/1ps
module decade_result_counter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, cnt_down = 1'b0, conv_end = 1'b0;
  logic [2:0] wsel = 3'd0;
  logic [1:0] lh_mode = 2'b00;
  logic [19:0] rd_mag;
  logic rd_neg, over_rng, under_rng, latch_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  decade_result_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_down(cnt_down), .wsel(wsel),
    .conv_end(conv_end), .lh_mode(lh_mode), .rd_mag(rd_mag), .rd_neg(rd_neg),
    .over_rng(over_rng), .under_rng(under_rng), .latch_n(latch_n)
  );

  // {down, wsel, expected reading, expected sign}
  localparam logic [24:0] VEC [19] = '{
    {1'b0, 3'd1, 20'h00001, 1'b0},
    {1'b0, 3'd4, 20'h01001, 1'b0},
    {1'b0, 3'd0, 20'h01001, 1'b0},
    {1'b1, 3'd5, 20'h08998, 1'b1},
    {1'b1, 3'd2, 20'h09008, 1'b1},
    {1'b0, 3'd4, 20'h08008, 1'b1},
    {1'b0, 3'd5, 20'h01991, 1'b0},
    {1'b1, 3'd1, 20'h01990, 1'b0},
    {1'b0, 3'd6, 20'h01990, 1'b0},
    {1'b1, 3'd3, 20'h01890, 1'b0},
    {1'b1, 3'd4, 20'h00890, 1'b0},
    {1'b1, 3'd4, 20'h00109, 1'b1},
    {1'b0, 3'd3, 20'h00009, 1'b1},
    {1'b0, 3'd0, 20'h00009, 1'b1},
    {1'b0, 3'd2, 20'h00000, 1'b0},
    {1'b1, 3'd0, 20'h00000, 1'b0},
    {1'b1, 3'd0, 20'h00000, 1'b0},
    {1'b1, 3'd0, 20'h00000, 1'b1},
    {1'b0, 3'd0, 20'h00000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic dn, input logic [2:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt_en = 1'b1; cnt_down = dn; wsel = w;
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic conv(input logic with_step);
    @(negedge clk);
    conv_end = 1'b1; cnt_en = with_step; cnt_down = 1'b0; wsel = 3'd5;
    @(negedge clk);
    conv_end = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic strobe_len(input string req, input int exp);
    int n = 0;
    while (!latch_n) begin
      n++;
      @(negedge clk);
    end
    chk(req, n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reading", rd_mag, 0);
    chk("R1 sign", rd_neg, 0);
    chk("R1 flags", {over_rng, under_rng}, 0);
    chk("R1 strobe", latch_n, 1);

    lh_mode = 2'b10;
    for (int v = 0; v < 19; v++) begin
      @(negedge clk);
      cnt_en = 1'b1; cnt_down = VEC[v][24]; wsel = VEC[v][23:21];
      @(negedge clk);
      cnt_en = 1'b0;
      chk($sformatf("R2 R3 R5 step %0d reading", v), rd_mag, VEC[v][20:1]);
      chk($sformatf("R3 R11 step %0d sign", v), rd_neg, VEC[v][0]);
    end

    step(1'b0, 3'd5, 10);
    chk("R4 saturate", rd_mag, 20'h99999);
    step(1'b0, 3'd0, 1);
    chk("R4 no wrap", rd_mag, 20'h99999);
    step(1'b1, 3'd1, 1);
    chk("R4 R5 after saturation", rd_mag, 20'h99998);

    conv(1'b1);
    chk("R6 cleared, step ignored", rd_mag, 0);
    chk("R9 R11 over flag", {over_rng, under_rng}, 2'b10);
    chk("R7 strobe low", latch_n, 0);
    strobe_len("R7 strobe length", 100);

    lh_mode = 2'b00;
    step(1'b0, 3'd5, 1); step(1'b0, 3'd4, 9); step(1'b0, 3'd3, 9);
    step(1'b0, 3'd2, 9); step(1'b0, 3'd1, 9);
    chk("R8 free-run steady", rd_mag, 20'h99998);
    conv(1'b0);
    chk("R8 capture 19999", rd_mag, 20'h19999);
    chk("R9 19999 in range", {over_rng, under_rng}, 2'b00);
    strobe_len("R7 strobe length", 100);

    step(1'b0, 3'd5, 2);
    conv(1'b0);
    chk("R9 20000 over", {over_rng, under_rng}, 2'b10);
    strobe_len("R7 strobe length", 100);

    step(1'b0, 3'd4, 1);
    conv(1'b0);
    chk("R8 capture 1000", rd_mag, 20'h01000);
    chk("R9 1000 not under", {over_rng, under_rng}, 2'b00);
    strobe_len("R7 strobe length", 100);

    step(1'b0, 3'd3, 9); step(1'b0, 3'd2, 9); step(1'b0, 3'd1, 9);
    conv(1'b0);
    chk("R9 999 under", {over_rng, under_rng}, 2'b01);
    strobe_len("R7 strobe length", 100);

    step(1'b1, 3'd5, 2);
    conv(1'b0);
    chk("R8 negative capture", {rd_neg, rd_mag}, {1'b1, 20'h20000});
    chk("R9 negative over", {over_rng, under_rng}, 2'b10);
    strobe_len("R7 strobe length", 100);

    lh_mode = 2'b01;
    step(1'b0, 3'd4, 1);
    conv(1'b0);
    chk("R10 held reading", {rd_neg, rd_mag}, {1'b1, 20'h20000});
    chk("R10 held flags", {over_rng, under_rng}, 2'b10);
    chk("R10 strobe pulses", latch_n, 0);
    strobe_len("R10 strobe length", 100);
    lh_mode = 2'b10;
    @(negedge clk);
    chk("R6 R10 counter cleared in hold", rd_mag, 0);

    conv(1'b0);
    repeat (9) @(negedge clk);
    conv(1'b0);
    strobe_len("R7 strobe restart", 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule